// File: doc/BRIEF.md
# Dual-Write Register File

This block is the integer register bank of a pipelined processor core. It holds a set of general-purpose words. It has two read ports that select a word by index and return it with no clock delay. It also has two write ports, each made of a destination index and a data word, and both are sampled on the rising clock edge. Index 0 is a hard-wired zero: it always reads as zero, and any write to it is dropped.

There is no separate write-enable pin. A write port is idle when its destination index is 0. A stage that has nothing to retire drives index 0. When both ports name the same nonzero register in one cycle, the second port (port B) sets the stored value. A read in the same cycle as a write to that register returns the old contents. Any forwarding is left to the surrounding pipeline.

Top module: `dual_wr_regfile`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register is cleared to zero. Reset takes priority over any write presented in that cycle.
- R2: The two read ports are independent. `rd_data_a` shows the register selected by `rd_idx_a`, and `rd_data_b` shows the register selected by `rd_idx_b`. Both are combinational from the index.
- R3: A read of index 0 returns zero on either port.
- R4: A nonzero `wr_idx_a` stores `wr_data_a` into that register at the rising clock edge, and it is readable right after that edge.
- R5: A nonzero `wr_idx_b` stores `wr_data_b` into that register at the rising clock edge, and it is readable right after that edge.
- R6: A write port whose index is 0 changes no register. A register that neither port names keeps its value.
- R7: When `wr_idx_a` equals `wr_idx_b` and both are nonzero, the register takes `wr_data_b`.
- R8: A read before the edge that writes the register returns the value stored before that edge. There is no write-to-read bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_idx_a | input | 5 | Register index for read port A |
| rd_data_a | output | 32 | Word read on port A |
| rd_idx_b | input | 5 | Register index for read port B |
| rd_data_b | output | 32 | Word read on port B |
| wr_idx_a | input | 5 | Destination index for write port A (0 = no write) |
| wr_data_a | input | 32 | Data word for write port A |
| wr_idx_b | input | 5 | Destination index for write port B (0 = no write) |
| wr_data_b | input | 32 | Data word for write port B |

## Verification
The bench targets five corner cases:
- Both ports write the same register in one cycle. A design with the priority reversed would keep port A's word.
- Writes are sent to index 0 with nonzero data. A design that stores them would return that data on a read of index 0, or would corrupt another register.
- A register is read in the same cycle it is written. A design with an unintended bypass would show the new word before the edge.
- Reset is asserted while both write ports are active. A design that gives writes priority would keep the written value after reset.
- Index 31 is exercised to catch an off-by-one in the write decode.

// File: rtl/rf_pkg.sv
// Package: shared types for the dual-write register file.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package rf_pkg;

    // Source that updates one register in a given cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_A    = 2'd1,
        SRC_B    = 2'd2
    } wr_src_e;

endpackage

// File: rtl/rf_write_decode.sv
// Module: rf_write_decode
// Turns the two write indices into one update source per register.
// Port B overrides port A on a shared target, and entry 0 never updates.
// Assumes: NREGS fits in AW index bits.
module rf_write_decode
    import rf_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int AW    = $clog2(NREGS)
) (
    input  logic [AW-1:0] wr_idx_a,
    input  logic [AW-1:0] wr_idx_b,
    output wr_src_e       src [NREGS]
);

    // Entry 0 is the hard-wired zero: it never takes a write.
    assign src[0] = SRC_NONE;

    genvar gi;
    generate
        for (gi = 1; gi < NREGS; gi++) begin : g_dec
            // Pick the update source for entry gi; port B has priority.
            always_comb begin
                if (wr_idx_b == AW'(gi))
                    src[gi] = SRC_B;
                else if (wr_idx_a == AW'(gi))
                    src[gi] = SRC_A;
                else
                    src[gi] = SRC_NONE;
            end
        end
    endgenerate

endmodule

// File: rtl/rf_storage.sv
// Module: rf_storage
// Holds the register words. Each entry updates from the source that the
// decoder picked, and all entries clear on a synchronous active-low reset.
// Entry 0 is a constant zero with no flop behind it.
// Assumes: src[0] is always SRC_NONE.
module rf_storage
    import rf_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wr_src_e       src [NREGS],
    input  logic [DW-1:0] wr_data_a,
    input  logic [DW-1:0] wr_data_b,
    output logic [DW-1:0] regs [NREGS]
);

    assign regs[0] = '0;

    genvar gi;
    generate
        for (gi = 1; gi < NREGS; gi++) begin : g_ent
            logic [DW-1:0] q;

            // Clear on reset, otherwise load the selected port's word.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    case (src[gi])
                        SRC_A:   q <= wr_data_a;
                        SRC_B:   q <= wr_data_b;
                        default: q <= q;
                    endcase
                end
            end

            assign regs[gi] = q;
        end
    endgenerate

endmodule

// File: rtl/rf_read_port.sv
// Module: rf_read_port
// One combinational read port. It forces zero on index 0, whatever the
// array holds there.
// Assumes: the index never exceeds NREGS-1 (true when NREGS is 2**AW).
module rf_read_port #(
    parameter int NREGS = 32,
    parameter int DW    = 32,
    parameter int AW    = $clog2(NREGS)
) (
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] regs [NREGS],
    output logic [DW-1:0] data
);

    // Select the addressed word; index 0 reads as zero.
    always_comb begin
        if (idx == '0)
            data = '0;
        else
            data = regs[idx];
    end

endmodule

// File: rtl/dual_wr_regfile.sv
// Module: dual_wr_regfile (top)
// Integer register file with two combinational read ports and two
// edge-triggered write ports. Index 0 reads zero and ignores writes.
// Port B wins a same-register collision, and there is no bypass.
// Assumes: a single clock domain; rst_n is synchronous to clk.
module dual_wr_regfile
    import rf_pkg::*;
#(
    parameter  int NREGS = 32,
    parameter  int DW    = 32,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [AW-1:0] rd_idx_b,
    output logic [DW-1:0] rd_data_b,
    input  logic [AW-1:0] wr_idx_a,
    input  logic [DW-1:0] wr_data_a,
    input  logic [AW-1:0] wr_idx_b,
    input  logic [DW-1:0] wr_data_b
);

    wr_src_e       src  [NREGS];
    logic [DW-1:0] regs [NREGS];

    rf_write_decode #(.NREGS(NREGS), .AW(AW)) u_dec (
        .wr_idx_a (wr_idx_a),
        .wr_idx_b (wr_idx_b),
        .src      (src)
    );

    rf_storage #(.NREGS(NREGS), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src),
        .wr_data_a (wr_data_a),
        .wr_data_b (wr_data_b),
        .regs      (regs)
    );

    rf_read_port #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_rd_a (
        .idx  (rd_idx_a),
        .regs (regs),
        .data (rd_data_a)
    );

    rf_read_port #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_rd_b (
        .idx  (rd_idx_b),
        .regs (regs),
        .data (rd_data_b)
    );

endmodule

// File: rtl/rf_checker.sv
// Module: rf_checker
// Port-level properties of dual_wr_regfile. Bound to the top below.
// Assumes: it watches only the top's ports.
module rf_checker #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] rd_idx_a,
    input logic [DW-1:0] rd_data_a,
    input logic [AW-1:0] rd_idx_b,
    input logic [DW-1:0] rd_data_b,
    input logic [AW-1:0] wr_idx_a,
    input logic [DW-1:0] wr_data_a,
    input logic [AW-1:0] wr_idx_b,
    input logic [DW-1:0] wr_data_b
);

    // Set once an out-of-reset edge has passed, so $past values are real.
    logic armed;
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd_data_a == '0 && rd_data_b == '0)); // R1

    AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_a == '0) |-> (rd_data_a == '0)); // R3

    AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_b == '0) |-> (rd_data_b == '0)); // R3

    AST_PORT_A_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(wr_idx_a) != '0 && $past(wr_idx_a) != $past(wr_idx_b)
         && rd_idx_a == $past(wr_idx_a)) |-> (rd_data_a == $past(wr_data_a))); // R4

    AST_PORT_B_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(wr_idx_b) != '0 && rd_idx_b == $past(wr_idx_b))
        |-> (rd_data_b == $past(wr_data_b))); // R7

    AST_UNTOUCHED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rd_idx_a == $past(rd_idx_a) && $past(wr_idx_a) != rd_idx_a
         && $past(wr_idx_b) != rd_idx_a) |-> $stable(rd_data_a)); // R6

endmodule

bind dual_wr_regfile rf_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx_a  (rd_idx_a),
    .rd_data_a (rd_data_a),
    .rd_idx_b  (rd_idx_b),
    .rd_data_b (rd_data_b),
    .wr_idx_a  (wr_idx_a),
    .wr_data_a (wr_data_a),
    .wr_idx_b  (wr_idx_b),
    .wr_data_b (wr_data_b)
);

// File: tb/sim_dual_wr_regfile.sv
// Bench: vector table, then directed cases for reset and no-bypass.
module sim_dual_wr_regfile;

    localparam int AW = 5;
    localparam int DW = 32;
    localparam int NV = 8;
    localparam int VW = 4*AW + 4*DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] rd_idx_a = '0, rd_idx_b = '0, wr_idx_a = '0, wr_idx_b = '0;
    logic [DW-1:0] wr_data_a = '0, wr_data_b = '0;
    logic [DW-1:0] rd_data_a, rd_data_b;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    dual_wr_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
        .wr_idx_a(wr_idx_a), .wr_data_a(wr_data_a),
        .wr_idx_b(wr_idx_b), .wr_data_b(wr_data_b)
    );

    // {wr_idx_a, wr_data_a, wr_idx_b, wr_data_b, rd_a, rd_b, exp_a, exp_b}
    localparam logic [VW-1:0] VEC [NV] = '{
        {5'd1,  32'h11111111, 5'd2,  32'h22222222, 5'd1,  5'd2,  32'h11111111, 32'h22222222}, // R4 R5 R2
        {5'd3,  32'hAAAA0003, 5'd3,  32'hBBBB0003, 5'd3,  5'd3,  32'hBBBB0003, 32'hBBBB0003}, // R7
        {5'd0,  32'hDEADBEEF, 5'd0,  32'hCAFEF00D, 5'd0,  5'd1,  32'h00000000, 32'h11111111}, // R6 R3
        {5'd31, 32'hFFFFFFFF, 5'd0,  32'h12345678, 5'd31, 5'd0,  32'hFFFFFFFF, 32'h00000000}, // R4 R6
        {5'd2,  32'h0000FFFF, 5'd5,  32'h00000005, 5'd2,  5'd5,  32'h0000FFFF, 32'h00000005}, // R4 R5
        {5'd0,  32'h00000000, 5'd0,  32'h00000000, 5'd3,  5'd31, 32'hBBBB0003, 32'hFFFFFFFF}, // R6
        {5'd7,  32'h00000007, 5'd7,  32'h00000070, 5'd7,  5'd1,  32'h00000070, 32'h11111111}, // R7
        {5'd9,  32'h00000009, 5'd10, 32'h00000010, 5'd10, 5'd9,  32'h00000010, 32'h00000009}  // R2
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        rd_idx_a = 5'd1; rd_idx_b = 5'd31;
        #2;
        check("R1 reset a", rd_data_a, '0);
        check("R1 reset b", rd_data_b, '0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {wr_idx_a, wr_data_a, wr_idx_b, wr_data_b, rd_idx_a, rd_idx_b} = VEC[i][VW-1:2*DW];
            @(posedge clk);
            #2;
            check($sformatf("vec%0d port a", i), rd_data_a, VEC[i][2*DW-1:DW]);
            check($sformatf("vec%0d port b", i), rd_data_b, VEC[i][DW-1:0]);
        end

        // R8: the read before the edge shows the old word, the read after shows the new one.
        @(negedge clk);
        wr_idx_a = 5'd1; wr_data_a = 32'h00000055; wr_idx_b = 5'd0;
        rd_idx_a = 5'd1; rd_idx_b = 5'd1;
        #2;
        check("R8 pre-edge a", rd_data_a, 32'h11111111);
        check("R8 pre-edge b", rd_data_b, 32'h11111111);
        @(posedge clk);
        #2;
        check("R8 post-edge", rd_data_a, 32'h00000055);

        // R1: reset overrides writes presented in the same cycle.
        @(negedge clk);
        rst_n = 1'b0;
        wr_idx_a = 5'd4; wr_data_a = 32'h44444444;
        wr_idx_b = 5'd31; wr_data_b = 32'h31313131;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; wr_idx_a = 5'd0; wr_idx_b = 5'd0;
        rd_idx_a = 5'd4; rd_idx_b = 5'd31;
        #2;
        check("R1 reset beats write a", rd_data_a, '0);
        check("R1 reset beats write b", rd_data_b, '0);
        rd_idx_a = 5'd7; rd_idx_b = 5'd3;
        #1;
        check("R1 cleared r7", rd_data_a, '0);
        check("R1 cleared r3", rd_data_b, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule